// File: doc/BRIEF.md
# Four-Lane Byte-Striped Transmit Distributor

The block sits between a 32-bit parallel MAC-side stream and four per-lane 8B/10B encoders. Every clock it takes one column: a 32-bit word plus one control flag per byte. It places byte n of that column on lane n, so each lane carries the same vertical byte order as the parallel bus. Each lane leaves as an 8-bit value and a control flag.

While passing packets through, the block rewrites control content into the lane code set. A column made only of idle bytes between packets becomes a whole column of comma code or a whole column of idle code. The two kinds alternate, and the alternation restarts with a comma column after every start of packet. Inside a column, the lanes above the first terminate byte are forced to the idle code. A start byte found anywhere except lane 0 raises an error flag.

The block has one register stage. All four lanes, and the error flag, change on the same clock edge.

Input control bytes (flag = 1) use these codes: 0x07 is idle, 0xFB is start, 0xFD is terminate. Output codes are: comma 0xBC, idle 0x1C, start 0xFB, terminate 0xFD.

Top module: `txs_lane_distributor`

## Requirements
- R1: A data byte (flag 0) on input byte n, bits 8n+7:8n, appears unchanged on lane n with its lane flag at 0. This holds even when the value equals a control code.
- R2: Every output depends only on the column captured at the previous rising clock edge, and all lanes update on that same edge.
- R3: A start byte (0xFB, flag 1) in lane 0 leaves on lane 0 as 0xFB with flag 1.
- R4: A terminate byte (0xFD, flag 1) in lane t leaves as 0xFD with flag 1 on lane t. Lanes above t carry the idle code 0x1C with flag 1. Lanes below t are unchanged.
- R5: When a column holds more than one terminate byte, only the lowest-numbered one counts. Every lane above it is idle-filled, including the lanes that held later terminates.
- R6: A column whose four bytes are all idle (0x07, flag 1) is sent as four lanes of one code, all with flag 1. Successive all-idle columns alternate between comma 0xBC and idle 0x1C, and the first after reset is comma.
- R7: The alternation advances only on all-idle columns. Any other column leaves it unchanged, and a start byte in lane 0 resets it so that the next all-idle column is comma.
- R8: An idle byte in a column that is not all idle, and not in a filled lane, leaves as 0x1C with flag 1.
- R9: An output flag `badStart` is 1 for exactly one cycle per column that holds a start byte in lane 1, 2 or 3, aligned with that column's lanes. It stays 1 even if that lane is idle-filled. A misplaced start does not reset the alternation.
- R10: During and right after reset, every lane shows 0x1C with flag 1, and `badStart` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inData | input | 32 | Column word, byte n for lane n |
| inCtl | input | 4 | Per-byte control flag, bit n for byte n |
| laneData | output | 32 | Lane n value at bits 8n+7:8n |
| laneCtl | output | 4 | Lane n control flag at bit n |
| badStart | output | 1 | Start byte seen outside lane 0 in the previous column |

## Verification
Two functions can fall in the same column: terminate fill and misplaced-start detection. The bench builds such a column with a terminate in lane 1 and a start in lane 3. The scoreboard expects lane 3 to carry the idle fill while `badStart` still rises on that same cycle. A second overlap is a packet start followed directly by idle columns after an odd number of earlier idles. There, the alternation reset must win over the left-over phase, and the first idle column must come out as comma.

// File: rtl/txs_pkg.sv
package txs_pkg;
  localparam int BW = 8;

  localparam logic [BW-1:0] IN_IDLE   = 8'h07;
  localparam logic [BW-1:0] IN_START  = 8'hFB;
  localparam logic [BW-1:0] IN_TERM   = 8'hFD;
  localparam logic [BW-1:0] OUT_COMMA = 8'hBC;
  localparam logic [BW-1:0] OUT_IDLE  = 8'h1C;

  typedef struct packed {
    logic allIdle;   // whole column is inter-packet idle
    logic commaSel;  // idle column should be sent as comma
    logic badStart;  // start byte outside lane 0
  } colStrobe_t;
endpackage

// File: rtl/txs_ctrl.sv
module txs_ctrl
  import txs_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [LANES*BW-1:0]   inData,
  input  logic [LANES-1:0]      inCtl,
  output colStrobe_t            strobe,
  output logic [LANES-1:0]      termMask,
  output logic [LANES-1:0]      fillMask
);
  logic [LANES-1:0] isIdle;
  logic [LANES-1:0] isStart;
  logic [LANES-1:0] isTerm;
  logic [LANES:0]   seenTerm;
  logic             phase;

  assign seenTerm[0] = 1'b0;

  for (genvar i = 0; i < LANES; i++) begin : g_decode
    logic [BW-1:0] laneByte;
    assign laneByte    = inData[i*BW +: BW];
    assign isIdle[i]   = inCtl[i] && (laneByte == IN_IDLE);
    assign isStart[i]  = inCtl[i] && (laneByte == IN_START);
    assign isTerm[i]   = inCtl[i] && (laneByte == IN_TERM);
    assign termMask[i] = isTerm[i] && !seenTerm[i];
    assign fillMask[i] = seenTerm[i];
    assign seenTerm[i+1] = seenTerm[i] | isTerm[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= 1'b0;
    end else if (isStart[0]) begin
      phase <= 1'b0;
    end else if (&isIdle) begin
      phase <= ~phase;
    end
  end

  always_comb begin
    strobe.allIdle  = &isIdle;
    strobe.commaSel = ~phase;
    strobe.badStart = |isStart[LANES-1:1];
  end
endmodule

// File: rtl/txs_datapath.sv
module txs_datapath
  import txs_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [LANES*BW-1:0]   inData,
  input  logic [LANES-1:0]      inCtl,
  input  colStrobe_t            strobe,
  input  logic [LANES-1:0]      termMask,
  input  logic [LANES-1:0]      fillMask,
  output logic [LANES*BW-1:0]   laneData,
  output logic [LANES-1:0]      laneCtl,
  output logic                  badStart
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [BW-1:0] inByte;
    logic [BW-1:0] nextByte;
    logic          nextCtl;

    assign inByte = inData[i*BW +: BW];

    always_comb begin
      if (strobe.allIdle) begin
        nextByte = strobe.commaSel ? OUT_COMMA : OUT_IDLE;
        nextCtl  = 1'b1;
      end else if (fillMask[i]) begin
        nextByte = OUT_IDLE;
        nextCtl  = 1'b1;
      end else if (termMask[i]) begin
        nextByte = IN_TERM;
        nextCtl  = 1'b1;
      end else if (inCtl[i] && (inByte == IN_IDLE)) begin
        nextByte = OUT_IDLE;
        nextCtl  = 1'b1;
      end else begin
        nextByte = inByte;
        nextCtl  = inCtl[i];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        laneData[i*BW +: BW] <= OUT_IDLE;
        laneCtl[i]           <= 1'b1;
      end else begin
        laneData[i*BW +: BW] <= nextByte;
        laneCtl[i]           <= nextCtl;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) badStart <= 1'b0;
    else     badStart <= strobe.badStart;
  end
endmodule

// File: rtl/txs_lane_distributor.sv
module txs_lane_distributor
  import txs_pkg::*;
#(
  parameter int LANES = 4,
  localparam int DW = LANES * BW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DW-1:0]    inData,
  input  logic [LANES-1:0] inCtl,
  output logic [DW-1:0]    laneData,
  output logic [LANES-1:0] laneCtl,
  output logic             badStart
);
  colStrobe_t       strobe;
  logic [LANES-1:0] termMask;
  logic [LANES-1:0] fillMask;

  txs_ctrl #(.LANES(LANES)) u_ctrl (
    .clk(clk), .rst(rst), .inData(inData), .inCtl(inCtl),
    .strobe(strobe), .termMask(termMask), .fillMask(fillMask)
  );

  txs_datapath #(.LANES(LANES)) u_dp (
    .clk(clk), .rst(rst), .inData(inData), .inCtl(inCtl),
    .strobe(strobe), .termMask(termMask), .fillMask(fillMask),
    .laneData(laneData), .laneCtl(laneCtl), .badStart(badStart)
  );
endmodule

// File: rtl/txs_checker.sv
module txs_checker
  import txs_pkg::*;
#(
  parameter int LANES = 4,
  localparam int DW = LANES * BW
) (
  input logic             clk,
  input logic             rst,
  input logic [DW-1:0]    inData,
  input logic [LANES-1:0] inCtl,
  input logic [DW-1:0]    laneData,
  input logic [LANES-1:0] laneCtl,
  input logic             badStart
);
  logic [LANES-1:0] idleIn;
  logic [LANES-1:0] startIn;
  logic allIdleIn;
  logic outComma;
  logic outIdle;

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    assign idleIn[i]  = inCtl[i] && (inData[i*BW +: BW] == IN_IDLE);
    assign startIn[i] = inCtl[i] && (inData[i*BW +: BW] == IN_START);
  end

  assign allIdleIn = &idleIn;
  assign outComma  = (laneData == {LANES{OUT_COMMA}}) && (&laneCtl);
  assign outIdle   = (laneData == {LANES{OUT_IDLE}}) && (&laneCtl);

  // R1 / R2: an all-data column passes through one cycle later
  a_r1_data_pass: assert property (@(posedge clk) disable iff (rst)
    (inCtl == '0) |=> (laneCtl == '0) && (laneData == $past(inData)));

  // R3: start in lane 0 is kept in lane 0
  a_r3_start_lane0: assert property (@(posedge clk) disable iff (rst)
    startIn[0] |=> laneCtl[0] && (laneData[BW-1:0] == IN_START));

  // R4: terminate in lane 0 fills the whole column
  a_r4_term_lane0: assert property (@(posedge clk) disable iff (rst)
    (inCtl[0] && inData[BW-1:0] == IN_TERM) |=>
      (&laneCtl) && (laneData[BW-1:0] == IN_TERM) &&
      (laneData[DW-1:BW] == {(LANES-1){OUT_IDLE}}));

  // R6: a comma column followed by another idle column gives an idle-code column
  a_r6_idle_alternates: assert property (@(posedge clk) disable iff (rst)
    (allIdleIn && outComma) |=> outIdle);

  // R9: error flag tracks misplaced start one cycle later
  a_r9_bad_start_set: assert property (@(posedge clk) disable iff (rst)
    (|startIn[LANES-1:1]) |=> badStart);

  a_r9_bad_start_clear: assert property (@(posedge clk) disable iff (rst)
    !(|startIn[LANES-1:1]) |=> !badStart);
endmodule

bind txs_lane_distributor txs_checker #(.LANES(LANES)) u_txs_checker (.*);

// File: tb/test_txs_lane_distributor.sv
`timescale 1ns/1ps
module test_txs_lane_distributor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] inData = 32'h07070707;
  logic [3:0]  inCtl  = 4'hF;
  logic [31:0] laneData;
  logic [3:0]  laneCtl;
  logic        badStart;

  int checks = 0;
  int errors = 0;
  bit modelPhase = 1'b0;

  typedef struct {
    logic [31:0] d;
    logic [3:0]  c;
    logic        e;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  txs_lane_distributor i_txs_lane_distributor (
    .clk(clk), .rst(rst), .inData(inData), .inCtl(inCtl),
    .laneData(laneData), .laneCtl(laneCtl), .badStart(badStart)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [36:0] act, input logic [36:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: spec model of one column, then drive and push expectation
  task automatic sendCol(input logic [31:0] d, input logic [3:0] c, input string tag);
    exp_t x;
    bit allIdle = 1'b1;
    bit seen = 1'b0;
    for (int i = 0; i < 4; i++)
      if (!(c[i] && d[8*i +: 8] == 8'h07)) allIdle = 1'b0;
    for (int i = 0; i < 4; i++) begin
      logic [7:0] b;
      b = d[8*i +: 8];
      if (allIdle) begin
        x.d[8*i +: 8] = modelPhase ? 8'h1C : 8'hBC; x.c[i] = 1'b1;
      end else if (seen) begin
        x.d[8*i +: 8] = 8'h1C; x.c[i] = 1'b1;
      end else if (c[i] && b == 8'hFD) begin
        x.d[8*i +: 8] = 8'hFD; x.c[i] = 1'b1; seen = 1'b1;
      end else if (c[i] && b == 8'h07) begin
        x.d[8*i +: 8] = 8'h1C; x.c[i] = 1'b1;
      end else begin
        x.d[8*i +: 8] = b; x.c[i] = c[i];
      end
    end
    x.e = 1'b0;
    for (int i = 1; i < 4; i++)
      if (c[i] && d[8*i +: 8] == 8'hFB) x.e = 1'b1;
    if (c[0] && d[7:0] == 8'hFB) modelPhase = 1'b0;
    else if (allIdle) modelPhase = ~modelPhase;
    x.tag = tag;
    #1;
    inData = d;
    inCtl  = c;
    @(posedge clk);
    sb.push_back(x);
  endtask

  // Monitor: compare one result per cycle, away from the active edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t x;
      x = sb.pop_front();
      check((laneData === x.d) && (laneCtl === x.c) && (badStart === x.e),
            x.tag, {badStart, laneCtl, laneData}, {x.e, x.c, x.d});
    end
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  localparam logic [31:0] IDL = 32'h07070707;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check((laneData === 32'h1C1C1C1C) && (laneCtl === 4'hF) && (badStart === 1'b0),
          "R10 reset state", {badStart, laneCtl, laneData}, {1'b0, 4'hF, 32'h1C1C1C1C});
    @(posedge clk);
    #1 rst = 1'b0;

    sendCol(IDL, 4'hF, "R6 first idle is comma");
    sendCol(IDL, 4'hF, "R6 second idle is idle code");
    sendCol(IDL, 4'hF, "R6 third idle is comma");
    // packet after odd idles: start must reset the phase
    sendCol(32'h332211FB, 4'h1, "R3 start in lane 0");
    sendCol(32'h07FD0607, 4'h0, "R1 data bytes incl. control values");
    sendCol(32'hDDCCBBAA, 4'h0, "R2 data column one cycle later");
    sendCol(32'h07FD4455, 4'hC, "R4 terminate lane 2");
    sendCol(IDL, 4'hF, "R7 start reset gives comma");
    sendCol(32'h123456FB, 4'h1, "R7 start before non-idle");
    sendCol(IDL, 4'hF, "R7 comma after start");
    sendCol(32'h00000001, 4'h0, "R7 data column holds phase");
    sendCol(IDL, 4'hF, "R7 phase held gives idle code");
    sendCol(32'h070707FD, 4'h1, "R4 terminate lane 0");
    sendCol(32'h0707FD11, 4'h2, "R4 terminate lane 1");
    sendCol(32'hFD332211, 4'h8, "R4 terminate lane 3");
    sendCol(32'hFD44FD11, 4'hA, "R5 lowest terminate wins");
    sendCol(32'h11070022, 4'h4, "R8 lone idle byte");
    sendCol(32'h33FB2211, 4'h4, "R9 start in lane 2");
    sendCol(32'h44332211, 4'h0, "R9 flag lasts one cycle");
    sendCol(32'hFB07FD11, 4'hE, "R9 misplaced start in filled lane");
    sendCol(IDL, 4'hF, "R9 misplaced start keeps phase");
    sendCol(IDL, 4'hF, "R6 alternation continues");

    @(negedge clk);
    #1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule